// File: doc/BRIEF.md
# BCH Page Geometry Calculator

This block works out the error-correction layout of a NAND page protected by a BCH code. It takes the page data size, the spare area size and a flag that selects the stronger engine variant. From these it computes the chunk size, the number of chunks, an even ECC strength that fits the spare budget, and two packed layout words for the codec configuration. It also finds where the factory bad-block mark lands once the page is seen through interleaved data and ECC chunks, and reports that position as a byte index plus a bit index.

A one-cycle `start` pulse launches a calculation. Three divisions then run in turn on one shared restoring divider, which produces one quotient bit per cycle. `busy` stays high for the whole run. `done` pulses for exactly one cycle when the results are written. A geometry the layout cannot serve raises `geom_err` and zeroes every result output. The results then hold until the next calculation finishes.

Top module: `bch_geom_calc`

## Requirements
- R1: The chunk size is 512 bytes. It becomes 1024 bytes when the spare size is greater than 512, so a spare size of exactly 512 keeps 512.
- R2: `geom_err` is set with `done` when any of these holds: the spare size exceeds the chosen chunk size, the spare size is below 10, or the page size is below the chunk size. On an error, chunk_bytes, chunk_count, ecc_strength, both layout words, mark_byte and mark_bit are all zero.
- R3: The chunk count is floor(page / chunk size).
- R4: The ECC strength is floor((spare − 10) × 8 / (13 × count)), rounded down to an even value, then limited to 40, or to 62 when `high_strength` is set.
- R5: Let P = page × 8 − 80 and T = chunk × 8 + 13 × strength. Let k = floor(P / T). The mark position is P − k × 13 × strength. mark_byte is that position shifted right by 3, and mark_bit is its low 3 bits.
- R6: If P mod T is greater than chunk × 8, the geometry is unsupported and is reported as in R2.
- R7: `aux_offset` always reads 12, which is the 10-byte metadata rounded up to a multiple of 4.
- R8: `layout_first` has these fields: bits [9:0] hold chunk/4, bit 10 holds 0 (selects the 13-bit field), bits [15:11] hold strength/2, bits [23:16] hold 10, and bits [29:24] hold count − 1.
- R9: `layout_page` has these fields: bits [9:0] hold chunk/4, bit 10 holds 0, bits [15:11] hold strength/2, and bits [31:16] hold page + spare.
- R10: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after start until `done`.
- R11: A `start` that arrives while `busy` is high is ignored. The result is the one for the inputs captured at the accepted start.
- R12: The result outputs change only in the cycle in which `done` is high. They hold while the inputs move without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a calculation; ignored while busy |
| page_bytes | input | PAGE_W | Page data size in bytes |
| spare_bytes | input | SPARE_W | Spare area size in bytes |
| high_strength | input | 1 | Raise the strength limit from 40 to 62 |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| geom_err | output | 1 | Geometry rejected |
| chunk_bytes | output | 11 | Chunk data size |
| chunk_count | output | PAGE_W-9 | Chunks per page |
| ecc_strength | output | 6 | Correctable bits per chunk |
| layout_first | output | PAGE_W+15 | Packed first layout word |
| layout_page | output | PAGE_W+17 | Packed second layout word |
| mark_byte | output | PAGE_W | Byte index of the bad-block mark |
| mark_bit | output | 3 | Bit index of the mark within that byte |
| aux_offset | output | 8 | Auxiliary status offset |

## Verification
The geometries are chosen to separate the strength paths. One strength lands exactly even, one is odd and must round down, one is limited to 40, and one is limited to 62; one case has the same inputs as another with only the flag changed, to show the limit follows the flag. Spare sizes of 512 and 513 pin down the chunk-size switch. A spare budget that gives strength 2 makes the mark fall off a byte boundary, which checks that the bit index is kept. Rejection is tried through each early test and through a small page whose mark falls inside the ECC bits, which reaches the R6 path only after all three divisions. Directed runs show that a start arriving mid-run and inputs changing after a run leave the results untouched.

// File: rtl/bch_geom_pkg.sv
package bch_geom_pkg;
  localparam int META_BYTES  = 10;
  localparam int META_BITS   = META_BYTES * 8;
  localparam int GF_BITS     = 13;
  localparam int BASE_CHUNK  = 512;
  localparam int WIDE_CHUNK  = BASE_CHUNK * 2;
  localparam int STR_LIM_LO  = 40;
  localparam int STR_LIM_HI  = 62;
  localparam int AUX_OFS     = ((META_BYTES + 3) / 4) * 4;

  typedef enum logic [1:0] {
    G_IDLE,
    G_COUNT,
    G_RAW,
    G_POS
  } geom_state_e;
endpackage

// File: rtl/bch_div.sv
module bch_div #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, d_r, n_r;
  logic [W:0]    r_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted, diff;

  always_comb begin
    shifted = {r_r[W-1:0], q_r[W-1]};
    diff    = shifted - {1'b0, d_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r  <= '0;
      d_r  <= '0;
      n_r  <= '0;
      r_r  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        q_r <= dividend;
        n_r <= dividend;
        d_r <= divisor;
        r_r <= '0;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (!diff[W]) begin
          r_r <= diff;
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= shifted;
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q_r;
  assign rem = r_r[W-1:0];

  // R3: quotient and remainder reconstruct the dividend
  a_r3_div_identity: assert property (@(posedge clk) disable iff (rst)
    done && d_r != '0 |->
      ((2*W)'(q_r) * (2*W)'(d_r) + (2*W)'(r_r) == (2*W)'(n_r)) && (r_r < {1'b0, d_r}));

  a_r10_div_one_shot: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/bch_strength.sv
module bch_strength #(
  parameter int W     = 18,
  parameter int STR_W = 6
) (
  input  logic [W-1:0]     raw,
  input  logic             hi,
  output logic [STR_W-1:0] strength
);
  import bch_geom_pkg::*;

  logic [W-1:0] even_v, lim_v;

  always_comb begin
    even_v   = raw & ~W'(1);
    lim_v    = hi ? W'(STR_LIM_HI) : W'(STR_LIM_LO);
    strength = (even_v > lim_v) ? STR_W'(lim_v) : STR_W'(even_v);
  end
endmodule

// File: rtl/bch_layout_pack.sv
module bch_layout_pack #(
  parameter int PAGE_W  = 15,
  parameter int SPARE_W = 11,
  parameter int CNT_W   = 6,
  parameter int CHUNK_W = 11,
  parameter int STR_W   = 6,
  parameter int L0_W    = CNT_W + 24,
  parameter int L1_W    = PAGE_W + 17
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [STR_W-1:0]   strength,
  input  logic [CHUNK_W-1:0] chunk,
  input  logic [PAGE_W-1:0]  page,
  input  logic [SPARE_W-1:0] spare,
  output logic [L0_W-1:0]    first_word,
  output logic [L1_W-1:0]    page_word
);
  import bch_geom_pkg::*;

  logic [9:0]        chunk_fld;
  logic [4:0]        half_fld;
  logic [PAGE_W:0]   total;

  always_comb begin
    chunk_fld  = 10'(chunk >> 2);
    half_fld   = 5'(strength >> 1);
    total      = (PAGE_W+1)'(page) + (PAGE_W+1)'(spare);
    first_word = {count - CNT_W'(1), 8'(META_BYTES), half_fld, 1'b0, chunk_fld};
    page_word  = {total, half_fld, 1'b0, chunk_fld};
  end
endmodule

// File: rtl/bch_geom_calc.sv
module bch_geom_calc #(
  parameter int PAGE_W  = 15,
  parameter int SPARE_W = 11,
  localparam int CNT_W   = PAGE_W - 9,
  localparam int CHUNK_W = 11,
  localparam int STR_W   = 6,
  localparam int L0_W    = CNT_W + 24,
  localparam int L1_W    = PAGE_W + 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PAGE_W-1:0]  page_bytes,
  input  logic [SPARE_W-1:0] spare_bytes,
  input  logic               high_strength,
  output logic               busy,
  output logic               done,
  output logic               geom_err,
  output logic [CHUNK_W-1:0] chunk_bytes,
  output logic [CNT_W-1:0]   chunk_count,
  output logic [STR_W-1:0]   ecc_strength,
  output logic [L0_W-1:0]    layout_first,
  output logic [L1_W-1:0]    layout_page,
  output logic [PAGE_W-1:0]  mark_byte,
  output logic [2:0]         mark_bit,
  output logic [7:0]         aux_offset
);
  import bch_geom_pkg::*;

  localparam int DW = PAGE_W + 3;

  geom_state_e        st;
  logic [PAGE_W-1:0]  page_q;
  logic [SPARE_W-1:0] spare_q;
  logic               hi_q;
  logic [CHUNK_W-1:0] cs_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [STR_W-1:0]   str_q;
  logic [DW-1:0]      eccb_q;

  logic               div_go, div_done;
  logic [DW-1:0]      div_n, div_d, div_q, div_r;

  logic [STR_W-1:0]   str_w;
  logic [CHUNK_W-1:0] cs_in;
  logic               early_err;
  logic [DW-1:0]      pos_w, cbits_w, mark_w;
  logic [L0_W-1:0]    l0_w;
  logic [L1_W-1:0]    l1_w;

  // R1 chunk choice and R2 early rejection
  always_comb begin
    cs_in     = (spare_bytes > SPARE_W'(BASE_CHUNK)) ? CHUNK_W'(WIDE_CHUNK)
                                                     : CHUNK_W'(BASE_CHUNK);
    early_err = (spare_bytes > SPARE_W'(cs_in)) ||
                (spare_bytes < SPARE_W'(META_BYTES)) ||
                (page_bytes < PAGE_W'(cs_in));
    pos_w     = {page_q, 3'b000} - DW'(META_BITS);
    cbits_w   = DW'({cs_q, 3'b000});
    mark_w    = pos_w - div_q * eccb_q;
  end

  bch_div #(.W(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (div_n),
    .divisor  (div_d),
    .done     (div_done),
    .quo      (div_q),
    .rem      (div_r)
  );

  bch_strength #(.W(DW), .STR_W(STR_W)) u_str (
    .raw      (div_q),
    .hi       (hi_q),
    .strength (str_w)
  );

  bch_layout_pack #(
    .PAGE_W (PAGE_W), .SPARE_W(SPARE_W), .CNT_W(CNT_W),
    .CHUNK_W(CHUNK_W), .STR_W(STR_W), .L0_W(L0_W), .L1_W(L1_W)
  ) u_pack (
    .count      (cnt_q),
    .strength   (str_q),
    .chunk      (cs_q),
    .page       (page_q),
    .spare      (spare_q),
    .first_word (l0_w),
    .page_word  (l1_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= G_IDLE;
      page_q       <= '0;
      spare_q      <= '0;
      hi_q         <= 1'b0;
      cs_q         <= '0;
      cnt_q        <= '0;
      str_q        <= '0;
      eccb_q       <= '0;
      div_go       <= 1'b0;
      div_n        <= '0;
      div_d        <= '0;
      done         <= 1'b0;
      geom_err     <= 1'b0;
      chunk_bytes  <= '0;
      chunk_count  <= '0;
      ecc_strength <= '0;
      layout_first <= '0;
      layout_page  <= '0;
      mark_byte    <= '0;
      mark_bit     <= '0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      case (st)
        G_IDLE: begin
          if (start) begin
            page_q  <= page_bytes;
            spare_q <= spare_bytes;
            hi_q    <= high_strength;
            cs_q    <= cs_in;
            if (early_err) begin
              done         <= 1'b1;
              geom_err     <= 1'b1;
              chunk_bytes  <= '0;
              chunk_count  <= '0;
              ecc_strength <= '0;
              layout_first <= '0;
              layout_page  <= '0;
              mark_byte    <= '0;
              mark_bit     <= '0;
            end else begin
              div_n  <= DW'(page_bytes);
              div_d  <= DW'(cs_in);
              div_go <= 1'b1;
              st     <= G_COUNT;
            end
          end
        end
        G_COUNT: begin
          if (div_done) begin
            cnt_q  <= CNT_W'(div_q);
            div_n  <= DW'({spare_q - SPARE_W'(META_BYTES), 3'b000});
            div_d  <= div_q * DW'(GF_BITS);
            div_go <= 1'b1;
            st     <= G_RAW;
          end
        end
        G_RAW: begin
          if (div_done) begin
            str_q  <= str_w;
            eccb_q <= DW'(str_w) * DW'(GF_BITS);
            div_n  <= pos_w;
            div_d  <= cbits_w + DW'(str_w) * DW'(GF_BITS);
            div_go <= 1'b1;
            st     <= G_POS;
          end
        end
        G_POS: begin
          if (div_done) begin
            st   <= G_IDLE;
            done <= 1'b1;
            if (div_r > cbits_w) begin
              geom_err     <= 1'b1;
              chunk_bytes  <= '0;
              chunk_count  <= '0;
              ecc_strength <= '0;
              layout_first <= '0;
              layout_page  <= '0;
              mark_byte    <= '0;
              mark_bit     <= '0;
            end else begin
              geom_err     <= 1'b0;
              chunk_bytes  <= cs_q;
              chunk_count  <= cnt_q;
              ecc_strength <= str_q;
              layout_first <= l0_w;
              layout_page  <= l1_w;
              mark_byte    <= mark_w[DW-1:3];
              mark_bit     <= mark_w[2:0];
            end
          end
        end
        default: st <= G_IDLE;
      endcase
    end
  end

  assign busy       = (st != G_IDLE);
  assign aux_offset = 8'(AUX_OFS);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_capture_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(page_q) && $stable(spare_q) && $stable(hi_q));

  a_r12_hold_results: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ecc_strength) && $stable(mark_byte) && $stable(mark_bit) &&
              $stable(layout_first) && $stable(layout_page) && $stable(geom_err));

  a_r4_even_clamped: assert property (@(posedge clk) disable iff (rst)
    done && !geom_err |->
      !ecc_strength[0] && (ecc_strength <= (hi_q ? STR_W'(STR_LIM_HI) : STR_W'(STR_LIM_LO))));

  a_r2_error_zeroes: assert property (@(posedge clk) disable iff (rst)
    done && geom_err |-> layout_first == '0 && layout_page == '0 && chunk_count == '0);
endmodule

// File: tb/bch_geom_calc_tb.sv
module bch_geom_calc_tb;
  typedef struct packed {
    logic [15:0] page;
    logic [11:0] spare;
    logic        hi;
    logic        err;
    logic [11:0] chunk;
    logic [7:0]  cnt;
    logic [7:0]  str;
    logic [15:0] mbyte;
    logic [3:0]  mbit;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [0:NV-1] = '{
    '{16'd2048, 12'd64,   1'b0, 1'b0, 12'd512,  8'd4, 8'd8,  16'd1999, 4'd0},
    '{16'd4096, 12'd224,  1'b0, 1'b0, 12'd512,  8'd8, 8'd16, 16'd3904, 4'd0},
    '{16'd4096, 12'd128,  1'b0, 1'b0, 12'd512,  8'd8, 8'd8,  16'd3995, 4'd0},
    '{16'd8192, 12'd640,  1'b1, 1'b0, 12'd1024, 8'd8, 8'd48, 16'd7636, 4'd0},
    '{16'd8192, 12'd640,  1'b0, 1'b0, 12'd1024, 8'd8, 8'd40, 16'd7727, 4'd0},
    '{16'd2048, 12'd24,   1'b0, 1'b0, 12'd512,  8'd4, 8'd2,  16'd2028, 4'd2},
    '{16'd560,  12'd64,   1'b0, 1'b1, 12'd0,    8'd0, 8'd0,  16'd0,    4'd0},
    '{16'd2048, 12'd1100, 1'b0, 1'b1, 12'd0,    8'd0, 8'd0,  16'd0,    4'd0},
    '{16'd256,  12'd16,   1'b0, 1'b1, 12'd0,    8'd0, 8'd0,  16'd0,    4'd0},
    '{16'd2048, 12'd8,    1'b0, 1'b1, 12'd0,    8'd0, 8'd0,  16'd0,    4'd0},
    '{16'd2048, 12'd512,  1'b1, 1'b0, 12'd512,  8'd4, 8'd62, 16'd1735, 4'd6},
    '{16'd2048, 12'd512,  1'b0, 1'b0, 12'd512,  8'd4, 8'd40, 16'd1843, 4'd0},
    '{16'd2048, 12'd513,  1'b0, 1'b0, 12'd1024, 8'd2, 8'd40, 16'd1973, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [14:0] page_bytes = '0;
  logic [10:0] spare_bytes = '0;
  logic        high_strength = 1'b0;
  logic        busy, done, geom_err;
  logic [10:0] chunk_bytes;
  logic [5:0]  chunk_count;
  logic [5:0]  ecc_strength;
  logic [29:0] layout_first;
  logic [31:0] layout_page;
  logic [14:0] mark_byte;
  logic [2:0]  mark_bit;
  logic [7:0]  aux_offset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bch_geom_calc u_dut (
    .clk(clk), .rst(rst), .start(start), .page_bytes(page_bytes),
    .spare_bytes(spare_bytes), .high_strength(high_strength), .busy(busy),
    .done(done), .geom_err(geom_err), .chunk_bytes(chunk_bytes),
    .chunk_count(chunk_count), .ecc_strength(ecc_strength),
    .layout_first(layout_first), .layout_page(layout_page),
    .mark_byte(mark_byte), .mark_bit(mark_bit), .aux_offset(aux_offset)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic kick(input vec_t v);
    @(negedge clk);
    page_bytes    = v.page[14:0];
    spare_bytes   = v.spare[10:0];
    high_strength = v.hi;
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input vec_t v);
    longint e0, e1;
    e0 = 0;
    e1 = 0;
    if (!v.err) begin
      e0 = (longint'(v.cnt - 1) << 24) | (longint'(10) << 16) |
           (longint'(v.str / 2) << 11) | longint'(v.chunk / 4);
      e1 = (longint'(v.page + v.spare) << 16) | (longint'(v.str / 2) << 11) |
           longint'(v.chunk / 4);
    end
    check("R2 R6 error flag", geom_err, v.err);
    check("R1 chunk size", chunk_bytes, v.chunk);
    check("R3 chunk count", chunk_count, v.cnt);
    check("R4 strength", ecc_strength, v.str);
    check("R5 mark byte", mark_byte, v.mbyte);
    check("R5 mark bit", mark_bit, v.mbit);
    check("R8 first layout word", layout_first, e0);
    check("R9 page layout word", layout_page, e1);
    check("R7 aux offset", aux_offset, 12);
  endtask

  initial begin
    bit ok;
    vec_t hold_v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset done", done, 0);
    check("R10 reset busy", busy, 0);
    check("R2 reset error", geom_err, 0);
    check("R4 reset strength", ecc_strength, 0);
    check("R7 reset aux", aux_offset, 12);

    for (int k = 0; k < NV; k++) begin
      kick(TBL[k]);
      if (!TBL[k].err || TBL[k].page >= 1024)
        ;
      wait_done(ok);
      check("R10 done seen", ok, 1);
      if (ok) begin
        check_result(TBL[k]);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        check("R10 idle after done", busy, 0);
      end
    end

    // R11: second start during a run is ignored
    kick(TBL[1]);
    check("R10 busy during run", busy, 1);
    repeat (5) @(negedge clk);
    page_bytes    = 15'd8192;
    spare_bytes   = 11'd640;
    high_strength = 1'b1;
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check("R11 done seen", ok, 1);
    if (ok) begin
      check_result(TBL[1]);
      @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check("R11 no second result", done, 0);
    check("R11 still idle", busy, 0);

    // R12: outputs hold while inputs move without start
    hold_v = TBL[1];
    page_bytes  = 15'd2048;
    spare_bytes = 11'd24;
    repeat (20) @(negedge clk);
    check("R12 strength held", ecc_strength, hold_v.str);
    check("R12 mark held", mark_byte, hold_v.mbyte);
    check("R12 no done", done, 0);

    finish_run();
  end
endmodule